// File: doc/BRIEF.md
# Signed Add, Subtract and Compare Unit

This unit works on two two's-complement operands of a configurable width (16 bits by default). A 2-bit opcode picks one of three operations. Add and subtract return the wrapped result and an overflow flag. Compare returns a 2-bit ordering code. One adder serves both add and subtract: for subtract it adds the inverted second operand plus one. Overflow comes from the operand and result sign bits alone.

For compare, each operand is moved into unsigned space by adding a bias of half the range. The two biased values are then compared as unsigned numbers. The inputs are sampled on a clock edge when a valid strobe is high, and all outputs come from one register stage. A host can issue one operation per cycle, back to back, and read each answer one cycle later.

Top module: `sgn_asc_unit`

## Requirements
- R1: Add (opcode 2'b00) returns `result` = (A + B) mod 2^W. Any carry beyond the top bit is dropped.
- R2: On add, `ovf_flag` is 1 exactly when A and B have the same sign bit and the sign bit of the sum differs from it. Otherwise it is 0.
- R3: An add whose operands have different sign bits never sets `ovf_flag`.
- R4: Subtract (opcode 2'b01) returns `result` = (A + ~B + 1) mod 2^W, which is A minus B wrapped to W bits.
- R5: On subtract, `ovf_flag` is 1 exactly when A and B have different sign bits and the sign bit of the result differs from the sign bit of A. Otherwise it is 0.
- R6: Compare (opcode 2'b10) treats A and B as signed values. It sets `cmp_code` to 2'b00 when A equals B, 2'b01 when A is less than B, and 2'b10 when A is greater than B. The code 2'b11 never appears.
- R7: A compare drives `result` to zero and `ovf_flag` to 0. Add and subtract drive `cmp_code` to 2'b00.
- R8: Opcode 2'b11 is reserved. It produces `result` zero, `ovf_flag` 0 and `cmp_code` 2'b00.
- R9: When `in_valid` is high at a rising clock edge, the outputs for those inputs appear after that edge. `out_valid` is high for exactly that one cycle.
- R10: When `in_valid` is low at a rising edge, `out_valid` is low after that edge. `result`, `ovf_flag` and `cmp_code` keep their previous values.
- R11: While `rst_n` is low, `out_valid`, `result`, `ovf_flag` and `cmp_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and opcode are sampled at this edge |
| op | input | 2 | 00 add, 01 subtract, 10 compare, 11 reserved |
| opnd_a | input | W | Operand A (minuend for subtract) |
| opnd_b | input | W | Operand B (subtrahend for subtract) |
| out_valid | output | 1 | A new result is on the outputs this cycle |
| result | output | W | Sum or difference; zero for compare and reserved |
| ovf_flag | output | 1 | Signed overflow of add or subtract |
| cmp_code | output | 2 | Ordering code of a compare |

## Verification
The bench builds the unit with W = 16, the default. At that width the most positive value 0x7FFF and the most negative value 0x8000 are used directly. This covers 0x7FFF plus one, 0x8000 minus one, zero minus 0x8000, and 0x8000 compared against 0x7FFF in both orders. These are the cases where a wrong sign rule or a missing bias shows up. A seeded sweep mixes all four opcodes with operands drawn often from the sign extremes. It alternates back-to-back issue with idle gaps, so that the hold behaviour and the one-cycle latency are checked between operations.

// File: rtl/sgn_asc_pkg.sv
package sgn_asc_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_CMP = 2'b10,
    OP_RSV = 2'b11
  } asc_op_e;

  localparam logic [1:0] CC_EQ = 2'b00;
  localparam logic [1:0] CC_LT = 2'b01;
  localparam logic [1:0] CC_GT = 2'b10;

endpackage

// File: rtl/sgn_asc_addsub.sv
module sgn_asc_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);
  localparam int MSB = W - 1;

  // wrapped sum with carry-in; the carry beyond MSB is not kept
  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] x,
                                            input logic [W-1:0] y,
                                            input logic         ci);
    return x + y + {{(W-1){1'b0}}, ci};
  endfunction

  // overflow from sign bits: like-signed inputs, result sign flipped
  function automatic logic sign_ovf(input logic sx, input logic sy,
                                    input logic sr);
    return (sx == sy) && (sr != sx);
  endfunction

  logic [W-1:0] b_eff;

  assign b_eff = sub ? ~b : b;
  assign sum   = wrap_add(a, b_eff, sub);
  assign ovf   = sign_ovf(a[MSB], b_eff[MSB], sum[MSB]);

endmodule

// File: rtl/sgn_asc_cmp.sv
module sgn_asc_cmp
  import sgn_asc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [1:0]   code,
  output logic         eq,
  output logic         lt,
  output logic         gt
);
  localparam logic [W-1:0] BIAS = {1'b1, {(W-1){1'b0}}};

  // shift the signed range onto the unsigned range
  function automatic logic [W-1:0] add_bias(input logic [W-1:0] x);
    return x + BIAS;
  endfunction

  logic [W-1:0] ua;
  logic [W-1:0] ub;

  assign ua = add_bias(a);
  assign ub = add_bias(b);
  assign eq = (ua == ub);
  assign lt = (ua < ub);
  assign gt = (ua > ub);

  always_comb begin
    if (gt)      code = CC_GT;
    else if (lt) code = CC_LT;
    else         code = CC_EQ;
  end

endmodule

// File: rtl/sgn_asc_outreg.sv
module sgn_asc_outreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d_res,
  input  logic         d_ovf,
  input  logic [1:0]   d_code,
  output logic         q_valid,
  output logic [W-1:0] q_res,
  output logic         q_ovf,
  output logic [1:0]   q_code
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_res   <= '0;
      q_ovf   <= 1'b0;
      q_code  <= 2'b00;
    end else begin
      q_valid <= load;
      if (load) begin
        q_res  <= d_res;
        q_ovf  <= d_ovf;
        q_code <= d_code;
      end
    end
  end

endmodule

// File: rtl/sgn_asc_unit.sv
module sgn_asc_unit
  import sgn_asc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         ovf_flag,
  output logic [1:0]   cmp_code
);

  asc_op_e      op_e;
  logic         is_sub;
  logic [W-1:0] as_sum;
  logic         as_ovf;
  logic [1:0]   cmp_code_w;
  logic         cmp_eq;
  logic         cmp_lt;
  logic         cmp_gt;
  logic [W-1:0] nxt_res;
  logic         nxt_ovf;
  logic [1:0]   nxt_code;

  assign op_e   = asc_op_e'(op);
  assign is_sub = (op_e == OP_SUB);

  sgn_asc_addsub #(.W(W)) u_addsub (
    .a   (opnd_a),
    .b   (opnd_b),
    .sub (is_sub),
    .sum (as_sum),
    .ovf (as_ovf)
  );

  sgn_asc_cmp #(.W(W)) u_cmp (
    .a    (opnd_a),
    .b    (opnd_b),
    .code (cmp_code_w),
    .eq   (cmp_eq),
    .lt   (cmp_lt),
    .gt   (cmp_gt)
  );

  always_comb begin
    nxt_res  = '0;
    nxt_ovf  = 1'b0;
    nxt_code = CC_EQ;
    case (op_e)
      OP_ADD, OP_SUB: begin
        nxt_res = as_sum;
        nxt_ovf = as_ovf;
      end
      OP_CMP:  nxt_code = cmp_code_w;
      default: ;
    endcase
  end

  sgn_asc_outreg #(.W(W)) u_outreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_valid),
    .d_res   (nxt_res),
    .d_ovf   (nxt_ovf),
    .d_code  (nxt_code),
    .q_valid (out_valid),
    .q_res   (result),
    .q_ovf   (ovf_flag),
    .q_code  (cmp_code)
  );

endmodule

// File: rtl/sgn_asc_unit_chk.sv
module sgn_asc_unit_chk
  import sgn_asc_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   op,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         ovf_flag,
  input logic [1:0]   cmp_code,
  input logic         cmp_eq,
  input logic         cmp_lt,
  input logic         cmp_gt
);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_ADD && (opnd_a[W-1] != opnd_b[W-1]) |=> !ovf_flag);

  p_sub_like_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_SUB && (opnd_a[W-1] == opnd_b[W-1]) |=> !ovf_flag);

  p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmp_code));

  p_one_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmp_eq, cmp_lt, cmp_gt}) == 1);

  p_equal_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_CMP && opnd_a == opnd_b |=> cmp_code == CC_EQ);

  p_cmp_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_CMP |=> result == '0 && !ovf_flag);

  p_arith_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op != OP_CMP |=> cmp_code == CC_EQ);

  p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_RSV |=> result == '0 && !ovf_flag);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(ovf_flag)
                  && $stable(cmp_code));

endmodule

bind sgn_asc_unit sgn_asc_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .out_valid (out_valid),
  .result    (result),
  .ovf_flag  (ovf_flag),
  .cmp_code  (cmp_code),
  .cmp_eq    (cmp_eq),
  .cmp_lt    (cmp_lt),
  .cmp_gt    (cmp_gt)
);

// File: tb/sgn_asc_unit_tb.sv
`timescale 1ns/1ps
module sgn_asc_unit_tb;
  localparam int W    = 16;
  localparam int MAXP = (1 << (W-1)) - 1;
  localparam int MINN = -(1 << (W-1));

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   op = 2'b00;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic         out_valid;
  logic [W-1:0] result;
  logic         ovf_flag;
  logic [1:0]   cmp_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;

  logic [W-1:0] q_res[$];
  logic         q_ovf[$];
  logic [1:0]   q_code[$];
  string        q_tag[$];

  logic [W-1:0] last_res  = '0;
  logic         last_ovf  = 1'b0;
  logic [1:0]   last_code = 2'b00;

  always #4 clk = ~clk;

  sgn_asc_unit #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
    .result(result), .ovf_flag(ovf_flag), .cmp_code(cmp_code)
  );

  // reference model written with wide signed integers
  task automatic model(input logic [1:0] o, input logic [W-1:0] x,
                       input logic [W-1:0] y, output logic [W-1:0] r,
                       output logic v, output logic [1:0] c,
                       output string t);
    int sx = $signed(x);
    int sy = $signed(y);
    int s;
    r = '0; v = 1'b0; c = 2'b00;
    case (o)
      2'b00: begin
        s = sx + sy; r = s[W-1:0]; v = (s > MAXP) || (s < MINN);
        t = v ? "R2" : ((x[W-1] != y[W-1]) ? "R3" : "R1");
      end
      2'b01: begin
        s = sx - sy; r = s[W-1:0]; v = (s > MAXP) || (s < MINN);
        t = v ? "R5" : "R4";
      end
      2'b10: begin
        c = (sx == sy) ? 2'b00 : ((sx < sy) ? 2'b01 : 2'b10);
        t = "R6 R7";
      end
      default: t = "R8";
    endcase
  endtask

  task automatic send(input logic [1:0] o, input logic [W-1:0] x,
                      input logic [W-1:0] y);
    logic [W-1:0] r; logic v; logic [1:0] c; string t;
    @(negedge clk);
    op = o; opnd_a = x; opnd_b = y; in_valid = 1'b1;
    model(o, x, y, r, v, c, t);
    q_res.push_back(r); q_ovf.push_back(v); q_code.push_back(c);
    q_tag.push_back(t);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (out_valid) begin
        checks++;
        if (q_res.size() == 0) begin
          fails++;
          $display("FAIL R9 unexpected out_valid: actual=1 expected=0");
        end else begin
          logic [W-1:0] er; logic eo; logic [1:0] ec; string et;
          er = q_res.pop_front(); eo = q_ovf.pop_front();
          ec = q_code.pop_front(); et = q_tag.pop_front();
          if (result !== er || ovf_flag !== eo || cmp_code !== ec) begin
            fails++;
            $display("FAIL %s R9 op=%b a=%h b=%h: actual res=%h ovf=%b code=%b expected res=%h ovf=%b code=%b",
                     et, op, opnd_a, opnd_b, result, ovf_flag, cmp_code, er, eo, ec);
          end
          last_res = er; last_ovf = eo; last_code = ec;
        end
      end else begin
        // R10: idle cycle keeps the previous outputs
        checks++;
        if (result !== last_res || ovf_flag !== last_ovf || cmp_code !== last_code) begin
          fails++;
          $display("FAIL R10 hold: actual res=%h ovf=%b code=%b expected res=%h ovf=%b code=%b",
                   result, ovf_flag, cmp_code, last_res, last_ovf, last_code);
        end
      end
    end
  end

  task automatic finish_up();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      finish_up();
    end
  end

  function automatic logic [W-1:0] pick();
    case ($urandom % 6)
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'hFFFF;
      3: return 16'h0000;
      default: return W'($urandom);
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || ovf_flag !== 1'b0 || cmp_code !== 2'b00) begin
      fails++;
      $display("FAIL R11 reset: actual v=%b res=%h ovf=%b code=%b expected all zero",
               out_valid, result, ovf_flag, cmp_code);
    end
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle(2);

    // R1 R2 R3 add corners
    send(2'b00, 16'h0001, 16'h0002);
    send(2'b00, 16'h7FFF, 16'h0001);
    send(2'b00, 16'h8000, 16'hFFFF);
    send(2'b00, 16'hFFFF, 16'h0001);
    send(2'b00, 16'h7FFF, 16'h8000);
    idle(2);
    // R4 R5 subtract corners
    send(2'b01, 16'h0005, 16'h0003);
    send(2'b01, 16'h8000, 16'h0001);
    send(2'b01, 16'h0000, 16'h8000);
    send(2'b01, 16'h7FFF, 16'hFFFF);
    send(2'b01, 16'hFFFF, 16'hFFFF);
    idle(1);
    // R6 R7 compare corners
    send(2'b10, 16'h8000, 16'h7FFF);
    send(2'b10, 16'h7FFF, 16'h8000);
    send(2'b10, 16'h1234, 16'h1234);
    send(2'b10, 16'hFFFF, 16'h0000);
    send(2'b10, 16'h8000, 16'h8000);
    // R8 reserved opcode after a nonzero result
    send(2'b00, 16'h7FFF, 16'h0001);
    send(2'b11, 16'h7FFF, 16'h0001);
    idle(3);

    for (int i = 0; i < 300; i++) begin
      send(2'($urandom % 4), pick(), pick());
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
    end
    idle(3);

    // R9: every issued operation produced exactly one result
    checks++;
    if (q_res.size() != 0) begin
      fails++;
      $display("FAIL R9 pending results: actual=%0d expected=0", q_res.size());
    end
    finish_up();
  end

endmodule